// File: doc/BRIEF.md
# Channelized Up/Down Tuning Counter

This block holds the division ratio N that a programmable frequency divider uses in a channelized synthesizer. A rotary tuning control produces bursts of pulses. Each pulse moves N by one count, up or down depending on a direction input. A coarser channel spacing is a multiple of the basic spacing, so its tuning steps arrive as two or four pulses. Both the pulse line and the direction line are asynchronous. They are brought into the system clock domain, and the counter acts only on the rising edge of each pulse.

The count is kept in a mixed-radix chain. The lowest stage is a 4-bit binary stage that wraps at 16. The next stage is a decade stage that wraps at 10. Above them sits a binary stage of `HI_W` bits. A spacing select forces the low-order bits that a coarser spacing makes redundant to zero on the way out, so the divider always sees a value on a channel boundary. The stored count itself is not changed by this masking.

The counter stops at programmable range limits. It raises a flag while it sits at either limit. A synchronous reset loads a programmable start value.

Top module: `tc_tuning_counter`

## Requirements
- R1: While `rst` is high at a clock edge, the count loads `N_START`, which defaults to 1000. Linear value means `bin + 16*dec + 160*hi`.
- R2: A rising edge on `tune_pulse` with `tune_up` high increases the linear value by exactly one. The change appears on the third rising clock edge after the pulse rises, counted from the first edge that samples it high.
- R3: A rising edge on `tune_pulse` with `tune_up` low decreases the linear value by exactly one, with the same latency as R2.
- R4: `n_word` is laid out as `{hi, dec[3:0], bin[3:0]}`. `bin` counts 0..15 and carries into `dec`. `dec` counts 0..9 and carries into `hi`. Borrows run the same way in reverse, so 1119 is shown as hi=6, dec=9, bin=15.
- R5: A pulse held high for any number of cycles counts once. The count does not change in any cycle without a detected rising edge.
- R6: `spacing` 2'b00 passes `n_word` unmasked. 2'b01 forces bit 0 to zero. 2'b10 and 2'b11 force bits 1:0 to zero. The masking never alters the stored count, so returning to 2'b00 shows the full value again.
- R7: When the linear value equals `N_MAX` (default 10000), `at_max` is high and up pulses leave the count unchanged.
- R8: When the linear value equals `N_MIN` (default 16), `at_min` is high and down pulses leave the count unchanged.
- R9: A reset asserted in the middle of tuning returns the count to `N_START`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_pulse | input | 1 | Asynchronous tuning pulse train |
| tune_up | input | 1 | Asynchronous direction: 1 counts up, 0 counts down |
| spacing | input | 2 | Spacing multiple: 00 basic, 01 double, 10/11 quadruple |
| n_word | output | 8+HI_W | Masked mixed-radix division ratio |
| at_max | output | 1 | Count sits at the upper limit |
| at_min | output | 1 | Count sits at the lower limit |

## Verification
The assertions check on every cycle the following properties:
- the decade digit stays within 0..9;
- the count moves only on a detected edge, and then by exactly one in the commanded direction;
- the linear value stays inside the range limits, and the top stage never wraps.

Only the bench's scenarios can show the rest: the three-edge latency, the exact digit patterns across binary and decade carries and borrows, the spacing masks, and the return of the unmasked value. A behavioural reference model in the bench is compared with all outputs on every clock. Long sweeps to both limits, a held pulse and a reset in the middle of tuning are included.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int BIN_W   = 4;
    localparam int DEC_W   = 4;
    localparam int BIN_MOD = 16;
    localparam int DEC_MOD = 10;
    localparam int STAGES  = 3;

    typedef enum logic [1:0] {
        SP_X1  = 2'b00,
        SP_X2  = 2'b01,
        SP_X4  = 2'b10,
        SP_X4B = 2'b11
    } spacing_e;

    function automatic int stage_w(int idx, int hi_w);
        return (idx == 0) ? BIN_W : ((idx == 1) ? DEC_W : hi_w);
    endfunction

    function automatic int stage_off(int idx);
        return (idx == 0) ? 0 : ((idx == 1) ? BIN_W : BIN_W + DEC_W);
    endfunction

    function automatic int stage_mod(int idx, int hi_w);
        return (idx == 0) ? BIN_MOD : ((idx == 1) ? DEC_MOD : (1 << hi_w));
    endfunction
endpackage

// File: rtl/tc_pulse_edge.sv
module tc_pulse_edge (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    input  logic dir_in,
    output logic step,
    output logic dir
);
    typedef struct packed {
        logic p1;
        logic p2;
        logic p3;
        logic d1;
        logic d2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.p1 = pulse_in;
        s_d.p2 = s_q.p1;
        s_d.p3 = s_q.p2;
        s_d.d1 = dir_in;
        s_d.d2 = s_q.d1;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign step = s_q.p2 & ~s_q.p3;
    assign dir  = s_q.d2;
endmodule

// File: rtl/tc_digit.sv
module tc_digit #(
    parameter int W   = 4,
    parameter int MOD = 10
) (
    input  logic [W-1:0] val,
    input  logic         en,
    input  logic         up,
    output logic [W-1:0] nxt,
    output logic         carry
);
    localparam logic [W-1:0] TOP = W'(MOD - 1);

    logic at_top, at_bot;

    always_comb begin
        at_top = (val == TOP);
        at_bot = (val == '0);
        carry  = en & (up ? at_top : at_bot);
        nxt    = val;
        if (en) begin
            if (up) nxt = at_top ? '0 : val + W'(1);
            else    nxt = at_bot ? TOP : val - W'(1);
        end
    end
endmodule

// File: rtl/tc_blank.sv
module tc_blank #(
    parameter int NW = 14
) (
    input  logic [NW-1:0] cnt,
    input  logic [1:0]    spacing,
    output logic [NW-1:0] word
);
    import tc_pkg::*;

    logic [NW-1:0] mask;

    always_comb begin
        mask = '1;
        case (spacing_e'(spacing))
            SP_X1:          mask = '1;
            SP_X2:          mask[0] = 1'b0;
            SP_X4, SP_X4B:  mask[1:0] = 2'b00;
            default:        mask = '1;
        endcase
        word = cnt & mask;
    end
endmodule

// File: rtl/tc_tuning_counter.sv
module tc_tuning_counter
    import tc_pkg::*;
#(
    parameter int HI_W    = 6,
    parameter int N_MIN   = 16,
    parameter int N_MAX   = 10000,
    parameter int N_START = 1000,
    localparam int NW     = BIN_W + DEC_W + HI_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tune_pulse,
    input  logic          tune_up,
    input  logic [1:0]    spacing,
    output logic [NW-1:0] n_word,
    output logic          at_max,
    output logic          at_min
);
    localparam int DEC_SPAN = BIN_MOD * DEC_MOD;
    localparam logic [NW-1:0] START_WORD = {
        HI_W'(N_START / DEC_SPAN),
        DEC_W'((N_START / BIN_MOD) % DEC_MOD),
        BIN_W'(N_START % BIN_MOD)
    };

    typedef struct packed {
        logic [NW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    logic          step, dir, allow;
    logic [NW-1:0] cnt_nxt;
    logic [STAGES:0] en;
    int            lin_q;

    tc_pulse_edge i_edge (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (tune_pulse),
        .dir_in   (tune_up),
        .step     (step),
        .dir      (dir)
    );

    always_comb begin
        lin_q = int'(st_q.cnt[BIN_W-1:0])
              + BIN_MOD * int'(st_q.cnt[BIN_W +: DEC_W])
              + DEC_SPAN * int'(st_q.cnt[NW-1 -: HI_W]);
        at_max = (lin_q >= N_MAX);
        at_min = (lin_q <= N_MIN);
        allow  = dir ? ~at_max : ~at_min;
    end

    assign en[0] = step & allow;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam int SW  = stage_w(g, HI_W);
        localparam int OFF = stage_off(g);
        localparam int MOD = stage_mod(g, HI_W);
        tc_digit #(.W(SW), .MOD(MOD)) i_digit (
            .val   (st_q.cnt[OFF +: SW]),
            .en    (en[g]),
            .up    (dir),
            .nxt   (cnt_nxt[OFF +: SW]),
            .carry (en[g+1])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.cnt <= START_WORD;
        else     st_q     <= st_d;
    end

    tc_blank #(.NW(NW)) i_blank (
        .cnt     (st_q.cnt),
        .spacing (spacing),
        .word    (n_word)
    );

    AST_DEC_DIGIT: assert property (@(posedge clk) disable iff (rst)
        int'(st_q.cnt[BIN_W +: DEC_W]) < DEC_MOD); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(st_q.cnt)); // R5
    AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && dir && !at_max) |=> (lin_q == $past(lin_q) + 1)); // R2
    AST_DN_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !dir && !at_min) |=> (lin_q == $past(lin_q) - 1)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (lin_q <= N_MAX) && !en[STAGES]); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        lin_q >= N_MIN); // R8
endmodule

// File: tb/test_tc_tuning_counter.sv
module test_tc_tuning_counter;
    localparam int PERIOD  = 10;
    localparam int HI_W    = 6;
    localparam int NW      = 8 + HI_W;
    localparam int N_MIN   = 16;
    localparam int N_MAX   = 10000;
    localparam int N_START = 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tune_pulse = 1'b0;
    logic tune_up = 1'b1;
    logic [1:0] spacing = 2'b00;
    logic [NW-1:0] n_word;
    logic at_max, at_min;

    int checks = 0;
    int errors = 0;
    int ref_n = N_START;
    int h1 = 0, h2 = 0, h3 = 0, d1 = 0, d2 = 0;
    bit model_ok = 1'b0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    tc_tuning_counter #(.HI_W(HI_W), .N_MIN(N_MIN), .N_MAX(N_MAX), .N_START(N_START)) i_tc_tuning_counter (
        .clk(clk), .rst(rst), .tune_pulse(tune_pulse), .tune_up(tune_up),
        .spacing(spacing), .n_word(n_word), .at_max(at_max), .at_min(at_min)
    );

    function automatic logic [NW-1:0] exp_word(int n, logic [1:0] sp);
        logic [NW-1:0] w;
        w = {HI_W'(n / 160), 4'((n / 16) % 10), 4'(n % 16)};
        if (sp == 2'b01) w[0] = 1'b0;
        else if (sp[1])  w[1:0] = 2'b00;
        return w;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // behavioural reference: three-sample edge delay, direction two samples
    always @(posedge clk) begin
        if (rst) begin
            ref_n = N_START; h1 = 0; h2 = 0; h3 = 0; d1 = 0; d2 = 0;
            model_ok = 1'b1;
        end else begin
            if (h2 == 1 && h3 == 0) begin
                if (d2 == 1 && ref_n < N_MAX) ref_n++;
                else if (d2 == 0 && ref_n > N_MIN) ref_n--;
            end
            h3 = h2; h2 = h1; h1 = int'(tune_pulse);
            d2 = d1; d1 = int'(tune_up);
        end
    end

    always @(negedge clk) begin
        #1;
        if (model_ok && !done) begin
            check("R2/R3/R4/R6 model word", int'(n_word), int'(exp_word(ref_n, spacing)));
            check("R7 model at_max", int'(at_max), int'(ref_n >= N_MAX));
            check("R8 model at_min", int'(at_min), int'(ref_n <= N_MIN));
        end
    end

    task automatic pulses(bit up, int n);
        for (int i = 0; i < n; i++) begin
            tune_up = up;
            tune_pulse = 1'b1;
            repeat (3) @(negedge clk);
            tune_pulse = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        #2;
        check("R1 reset word", int'(n_word), int'(exp_word(1000, 2'b00)));
        check("R1 reset flags", int'({at_max, at_min}), 0);

        pulses(1'b1, 8);
        #2 check("R2 R4 up carry bin->dec", int'(n_word), int'({6'd6, 4'd3, 4'd0}));
        pulses(1'b0, 3);
        #2 check("R3 down", int'(n_word), int'(exp_word(1005, 2'b00)));

        tune_up = 1'b1; tune_pulse = 1'b1;
        repeat (20) @(negedge clk);
        tune_pulse = 1'b0;
        repeat (3) @(negedge clk);
        #2 check("R5 held pulse once", int'(n_word), int'(exp_word(1006, 2'b00)));

        pulses(1'b1, 1);
        spacing = 2'b01;
        #2 check("R6 x2 blank", int'(n_word), int'(exp_word(1007, 2'b00) & ~14'd1));
        @(negedge clk); spacing = 2'b10;
        #2 check("R6 x4 blank", int'(n_word[1:0]), 0);
        @(negedge clk); spacing = 2'b11;
        #2 check("R6 code 11 blank", int'(n_word[1:0]), 0);
        @(negedge clk); spacing = 2'b00;
        #2 check("R6 unmasked restore", int'(n_word), int'(exp_word(1007, 2'b00)));

        spacing = 2'b01;
        pulses(1'b1, 113);
        #2 check("R4 dec->hi carry", int'(n_word), int'({6'd7, 4'd0, 4'd0}));
        spacing = 2'b00;
        pulses(1'b0, 1);
        #2 check("R4 borrow 1119", int'(n_word), int'({6'd6, 4'd9, 4'd15}));

        pulses(1'b1, 5);
        rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
        #2 check("R9 mid-run reset", int'(n_word), int'(exp_word(1000, 2'b00)));

        pulses(1'b0, 984 + 3);
        #2 check("R8 min word", int'(n_word), int'(exp_word(N_MIN, 2'b00)));
        check("R8 at_min", int'(at_min), 1);

        do_reset();
        pulses(1'b1, 9000 + 3);
        #2 check("R7 max word", int'(n_word), int'(exp_word(N_MAX, 2'b00)));
        check("R7 at_max", int'(at_max), 1);
        pulses(1'b0, 1);
        #2 check("R7 leave max", int'(at_max), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule